// File: doc/BRIEF.md
# Channel Event Interrupt Collector

This block gathers short event pulses from ten capture/playback channel pairs and turns them into sticky pending flags. Each channel has six event kinds: almost-empty, almost-full and overflow, once for the capture direction and once for the playback direction. A flag sets on its pulse and stays set until software clears it by writing a one to the matching clear bit.

Software gives each event its own enable. The masked view shows the pending flags that are also enabled. A second, per-channel enable decides whether a channel may drive the single interrupt line at all. The line is registered, and it is high when at least one channel has its channel enable set and at least one masked flag pending.

The register port is a plain single-cycle strobe interface with a combinational read path. There is no data stream through this block, so it has no valid/ready handshake. Each register holds four 8-bit channel lanes. There are four views (enable, clear, raw and masked), and each view spans three registers.

Top module: `chan_irq_collector`

## Requirements
- R1: Channel c owns the 8-bit lane at bit offset 8*(c mod 4) of register index c/4, rounded down, so channels 0-3, 4-7 and 8-9 share registers 0, 1 and 2. Inside a lane, bit 0 is capture almost-empty, bit 1 capture almost-full, bit 2 playback almost-empty, bit 3 playback almost-full, bit 4 capture overflow and bit 5 playback overflow. Lane bits 6 and 7 read as zero. Event e of channel c arrives on `ev_pulse_i[c*6+e]`.
- R2: A one on an event input sets the matching raw flag at the next rising clock edge, and the raw view shows it from then on.
- R3: A raw flag stays set, with or without further pulses, until it is cleared.
- R4: Writing a register of the clear view removes every raw flag whose bit is written as one and leaves flags written as zero untouched. If a pulse and a clear reach the same flag in the same cycle, the flag stays set.
- R5: Each bit of the masked view is the raw flag ANDed with its per-event enable. A flag whose enable is zero never raises the interrupt.
- R6: `irq_o` is a register. It is high in the cycle after a cycle in which some channel has both a masked flag pending and its channel enable set, and it is low otherwise.
- R7: The channel enable sits at address 3, bits 9:0, with bit c for channel c. A channel whose bit is zero does not raise `irq_o`, whatever its masked flags are.
- R8: `reg_addr_i[3:2]` selects the view: 0 is enable (read/write), 1 is clear (write-only, reads zero), 2 is raw (read-only) and 3 is masked (read-only). `reg_addr_i[1:0]` selects register 0 to 2. Index 3 of the enable view is the channel enable. Index 3 of any other view reads zero, and writes to it are ignored, as are writes to the raw and masked views.
- R9: Reset clears all raw flags, per-event enables, channel enables and `irq_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ev_pulse_i | input | 60 | Event pulses, channel c event e at bit c*6+e |
| reg_wr_i | input | 1 | Register write strobe, one cycle per write |
| reg_addr_i | input | 4 | View in bits 3:2, register index in bits 1:0 |
| reg_wdata_i | input | 32 | Write data |
| reg_rdata_o | output | 32 | Combinational read data for `reg_addr_i` |
| irq_o | output | 1 | Registered combined interrupt |

## Verification
The assertions assume that a write strobe is sampled only on the edge where the address and data are valid. Event inputs may be high in any cycle, on any number of bits at once, including the cycle of a clear write. They also assume that reset is applied before the first checked edge. The stimulus changes every input half a cycle away from the rising edge and holds it for a whole cycle. It mixes directed sequences with a long pseudo-random run, in which pulses, clears, enable writes and writes to read-only views arrive together. That run includes clears that land in the same cycle as the pulse they target.

// File: rtl/cic_pkg.sv
`timescale 1ns/1ps
package cic_pkg;
  // Register view selected by the two upper address bits.
  typedef enum logic [1:0] {
    VIEW_EN  = 2'd0,
    VIEW_CLR = 2'd1,
    VIEW_RAW = 2'd2,
    VIEW_MSK = 2'd3
  } view_e;
endpackage

// File: rtl/cic_lane.sv
`timescale 1ns/1ps
// Per-channel sticky flags, per-event enables and request.
module cic_lane #(
  parameter int EV_W = 6
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [EV_W-1:0] ev_i,
  input  logic            en_we_i,
  input  logic [EV_W-1:0] en_wdata_i,
  input  logic [EV_W-1:0] clr_mask_i,
  input  logic            top_en_i,
  output logic [EV_W-1:0] raw_o,
  output logic [EV_W-1:0] en_o,
  output logic [EV_W-1:0] msk_o,
  output logic            req_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      raw_o <= '0;
      en_o  <= '0;
    end else begin
      // a pulse in the clearing cycle keeps the flag set
      raw_o <= ev_i | (raw_o & ~clr_mask_i);
      if (en_we_i) en_o <= en_wdata_i;
    end
  end

  assign msk_o = raw_o & en_o;
  assign req_o = top_en_i & (|msk_o);
endmodule

// File: rtl/cic_regif.sv
`timescale 1ns/1ps
// Address decode, channel enable register and read mux.
module cic_regif import cic_pkg::*; #(
  parameter int NUM_CH     = 10,
  parameter int EV_W       = 6,
  parameter int CH_PER_REG = 4,
  parameter int DATA_W     = 32,
  parameter int ADDR_W     = 4
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   wr_i,
  input  logic [ADDR_W-1:0]      addr_i,
  input  logic [DATA_W-1:0]      wdata_i,
  input  logic [NUM_CH*EV_W-1:0] raw_i,
  input  logic [NUM_CH*EV_W-1:0] msk_i,
  input  logic [NUM_CH*EV_W-1:0] en_i,
  output logic [NUM_CH-1:0]      en_we_o,
  output logic [NUM_CH*EV_W-1:0] en_wdata_o,
  output logic [NUM_CH*EV_W-1:0] clr_mask_o,
  output logic [NUM_CH-1:0]      top_en_o,
  output logic [DATA_W-1:0]      rdata_o
);
  localparam int IDX_W  = ADDR_W - 2;
  localparam int LANE_W = DATA_W / CH_PER_REG;
  localparam logic [IDX_W-1:0] TOP_IDX = {IDX_W{1'b1}};

  view_e            view;
  logic [IDX_W-1:0] idx;
  logic             top_sel;
  logic [DATA_W-1:0] part [NUM_CH];
  logic             unused_wbits;

  assign view    = view_e'(addr_i[ADDR_W-1 -: 2]);
  assign idx     = addr_i[IDX_W-1:0];
  assign top_sel = (view == VIEW_EN) && (idx == TOP_IDX);
  assign unused_wbits = ^wdata_i;

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    localparam int REG_IX = c / CH_PER_REG;
    localparam int LANE   = c % CH_PER_REG;
    logic            hit;
    logic [EV_W-1:0] wsl;
    logic [EV_W-1:0] rsel;

    assign hit = (idx == IDX_W'(REG_IX));
    assign wsl = wdata_i[LANE*LANE_W +: EV_W];

    assign en_we_o[c]                  = wr_i && (view == VIEW_EN) && hit;
    assign en_wdata_o[c*EV_W +: EV_W]  = wsl;
    assign clr_mask_o[c*EV_W +: EV_W]  =
      (wr_i && (view == VIEW_CLR) && hit) ? wsl : '0;

    always_comb begin
      case (view)
        VIEW_EN:  rsel = en_i[c*EV_W +: EV_W];
        VIEW_RAW: rsel = raw_i[c*EV_W +: EV_W];
        VIEW_MSK: rsel = msk_i[c*EV_W +: EV_W];
        default:  rsel = '0;
      endcase
    end

    assign part[c] = hit ? (DATA_W'(rsel) << (LANE*LANE_W)) : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              top_en_o <= '0;
    else if (wr_i && top_sel) top_en_o <= wdata_i[NUM_CH-1:0];
  end

  always_comb begin
    rdata_o = '0;
    for (int c = 0; c < NUM_CH; c++) rdata_o = rdata_o | part[c];
    if (top_sel) rdata_o[NUM_CH-1:0] = top_en_o;
  end
endmodule

// File: rtl/cic_combine.sv
`timescale 1ns/1ps
// OR of channel requests into the registered interrupt line.
module cic_combine #(
  parameter int NUM_CH = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_CH-1:0] req_i,
  output logic              irq_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq_o <= 1'b0;
    else        irq_o <= |req_i;
  end
endmodule

// File: rtl/chan_irq_collector.sv
`timescale 1ns/1ps
module chan_irq_collector #(
  parameter int NUM_CH     = 10,
  parameter int EV_W       = 6,
  parameter int CH_PER_REG = 4,
  parameter int DATA_W     = 32,
  parameter int ADDR_W     = 4
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [NUM_CH*EV_W-1:0] ev_pulse_i,
  input  logic                   reg_wr_i,
  input  logic [ADDR_W-1:0]      reg_addr_i,
  input  logic [DATA_W-1:0]      reg_wdata_i,
  output logic [DATA_W-1:0]      reg_rdata_o,
  output logic                   irq_o
);
  localparam int FLAG_W = NUM_CH * EV_W;

  logic [FLAG_W-1:0] raw_vec, msk_vec, en_vec, en_wdata, clr_mask;
  logic [NUM_CH-1:0] en_we, top_en, req;

  cic_regif #(
    .NUM_CH(NUM_CH), .EV_W(EV_W), .CH_PER_REG(CH_PER_REG),
    .DATA_W(DATA_W), .ADDR_W(ADDR_W)
  ) u_regif (
    .clk(clk), .rst_n(rst_n),
    .wr_i(reg_wr_i), .addr_i(reg_addr_i), .wdata_i(reg_wdata_i),
    .raw_i(raw_vec), .msk_i(msk_vec), .en_i(en_vec),
    .en_we_o(en_we), .en_wdata_o(en_wdata), .clr_mask_o(clr_mask),
    .top_en_o(top_en), .rdata_o(reg_rdata_o)
  );

  for (genvar c = 0; c < NUM_CH; c++) begin : g_lane
    cic_lane #(.EV_W(EV_W)) u_lane (
      .clk(clk), .rst_n(rst_n),
      .ev_i(ev_pulse_i[c*EV_W +: EV_W]),
      .en_we_i(en_we[c]),
      .en_wdata_i(en_wdata[c*EV_W +: EV_W]),
      .clr_mask_i(clr_mask[c*EV_W +: EV_W]),
      .top_en_i(top_en[c]),
      .raw_o(raw_vec[c*EV_W +: EV_W]),
      .en_o(en_vec[c*EV_W +: EV_W]),
      .msk_o(msk_vec[c*EV_W +: EV_W]),
      .req_o(req[c])
    );
  end

  cic_combine #(.NUM_CH(NUM_CH)) u_combine (
    .clk(clk), .rst_n(rst_n), .req_i(req), .irq_o(irq_o)
  );
endmodule

// File: rtl/cic_chk.sv
`timescale 1ns/1ps
module cic_chk #(
  parameter int NUM_CH = 10,
  parameter int EV_W   = 6
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic [NUM_CH*EV_W-1:0] ev_i,
  input logic [NUM_CH*EV_W-1:0] clr_i,
  input logic [NUM_CH*EV_W-1:0] raw_i,
  input logic [NUM_CH*EV_W-1:0] msk_i,
  input logic [NUM_CH-1:0]      top_i,
  input logic                   irq_i
);
  for (genvar i = 0; i < NUM_CH*EV_W; i++) begin : g_bit
    a_r2_event_sets: assert property (@(posedge clk) disable iff (!rst_n)
      ev_i[i] |=> raw_i[i]);
    a_r3_flag_holds: assert property (@(posedge clk) disable iff (!rst_n)
      (raw_i[i] && !clr_i[i]) |=> raw_i[i]);
    a_r3_no_spontaneous: assert property (@(posedge clk) disable iff (!rst_n)
      (!raw_i[i] && !ev_i[i]) |=> !raw_i[i]);
    a_r4_clear_drops: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_i[i] && !ev_i[i]) |=> !raw_i[i]);
  end

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    a_r6_channel_fires: assert property (@(posedge clk) disable iff (!rst_n)
      (top_i[c] && (|msk_i[c*EV_W +: EV_W])) |=> irq_i);
  end

  a_r7_all_gated: assert property (@(posedge clk) disable iff (!rst_n)
    (top_i == '0) |=> !irq_i);
  a_r5_quiet_when_masked: assert property (@(posedge clk) disable iff (!rst_n)
    (msk_i == '0) |=> !irq_i);
endmodule

bind chan_irq_collector cic_chk #(.NUM_CH(NUM_CH), .EV_W(EV_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .ev_i(ev_pulse_i), .clr_i(clr_mask),
  .raw_i(raw_vec), .msk_i(msk_vec), .top_i(top_en), .irq_i(irq_o)
);

// File: tb/chan_irq_collector_test.sv
`timescale 1ns/1ps
module chan_irq_collector_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr = 1'b0;
  logic [3:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [59:0] ev = '0;
  logic [31:0] rdata;
  logic        irq;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  bit m_raw [60];
  bit m_en  [60];
  bit m_top [10];
  bit m_irq;

  always #4 clk = ~clk;

  chan_irq_collector uut (
    .clk(clk), .rst_n(rst_n), .ev_pulse_i(ev), .reg_wr_i(wr),
    .reg_addr_i(addr), .reg_wdata_i(wdata), .reg_rdata_o(rdata), .irq_o(irq)
  );

  // behavioural reference, one update per rising edge
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < 60; i++) begin m_raw[i] = 0; m_en[i] = 0; end
      for (int c = 0; c < 10; c++) m_top[c] = 0;
      m_irq = 0;
    end else begin
      bit nirq;
      nirq = 0;
      for (int c = 0; c < 10; c++)
        for (int e = 0; e < 6; e++)
          if (m_top[c] && m_raw[c*6+e] && m_en[c*6+e]) nirq = 1;
      for (int c = 0; c < 10; c++)
        for (int e = 0; e < 6; e++) begin
          bit clr;
          clr = wr && addr[3:2] == 2'd1 && int'(addr[1:0]) == c/4
                && wdata[(c%4)*8+e];
          m_raw[c*6+e] = ev[c*6+e] | (m_raw[c*6+e] & !clr);
          if (wr && addr[3:2] == 2'd0 && int'(addr[1:0]) == c/4)
            m_en[c*6+e] = wdata[(c%4)*8+e];
        end
      if (wr && addr == 4'd3)
        for (int c = 0; c < 10; c++) m_top[c] = wdata[c];
      m_irq = nirq;
    end
  end

  function automatic logic [31:0] model_rd(input logic [3:0] a);
    logic [31:0] r;
    int v, ix;
    r = '0;
    v = int'(a[3:2]);
    ix = int'(a[1:0]);
    if (v == 0 && ix == 3) begin
      for (int c = 0; c < 10; c++) r[c] = m_top[c];
    end else if (ix < 3 && v != 1) begin
      for (int c = 0; c < 10; c++)
        if (c/4 == ix)
          for (int e = 0; e < 6; e++)
            r[(c%4)*8+e] = (v == 0) ? m_en[c*6+e] :
                           (v == 2) ? m_raw[c*6+e] :
                                      (m_raw[c*6+e] & m_en[c*6+e]);
    end
    return r;
  endfunction

  task automatic check(input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
    end
  endtask

  // interrupt compared against the reference on every cycle
  always @(negedge clk)
    if (!done) check("R6 irq vs reference", {31'd0, irq}, {31'd0, m_irq});

  task automatic wr_reg(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk); wr = 1'b1; addr = a; wdata = d;
    @(negedge clk); wr = 1'b0;
  endtask

  task automatic pulse(input logic [59:0] v);
    @(negedge clk); ev = v;
    @(negedge clk); ev = '0;
  endtask

  task automatic rd_exp(input logic [3:0] a, input logic [31:0] exp,
                        input string tag);
    addr = a; #1;
    check(tag, rdata, exp);
    check({tag, " (reference)"}, rdata, model_rd(a));
  endtask

  function automatic logic [31:0] xs(input logic [31:0] x);
    logic [31:0] y;
    y = x ^ (x << 13);
    y = y ^ (y >> 17);
    y = y ^ (y << 5);
    return y;
  endfunction

  initial begin
    logic [31:0] lf;
    lf = 32'h1234_5678;
    repeat (3) @(negedge clk);
    #2 rst_n = 1'b1;
    @(negedge clk);
    for (int a = 0; a < 16; a++) rd_exp(4'(a), 32'h0, "R9 reset read");

    // enables, lane layout and unused bits
    wr_reg(4'd0, 32'hFFFF_FFFF);
    wr_reg(4'd1, 32'hFFFF_FFFF);
    wr_reg(4'd2, 32'hFFFF_FFFF);
    rd_exp(4'd0, 32'h3F3F_3F3F, "R1 enable lanes reg0");
    rd_exp(4'd2, 32'h0000_3F3F, "R1 enable lanes reg2");
    wr_reg(4'd3, 32'hFFFF_FFFF);
    rd_exp(4'd3, 32'h0000_03FF, "R7 channel enable width");

    // channel 5 capture almost-full -> reg1 bit 9
    pulse(60'd1 << 31);
    rd_exp(4'd9, 32'h0000_0200, "R2 raw set");
    check("R6 irq one cycle late", {31'd0, irq}, 32'd0);
    @(negedge clk);
    check("R6 irq asserted", {31'd0, irq}, 32'd1);
    repeat (5) @(negedge clk);
    rd_exp(4'd9, 32'h0000_0200, "R3 flag held");

    wr_reg(4'd5, 32'h0000_0001);
    rd_exp(4'd9, 32'h0000_0200, "R4 zero bits leave flag");
    wr_reg(4'd5, 32'h0000_0200);
    rd_exp(4'd9, 32'h0, "R4 clear removes flag");
    @(negedge clk);
    check("R6 irq drops", {31'd0, irq}, 32'd0);

    // channel 2 playback almost-full: pulse and clear together
    @(negedge clk); ev = 60'd1 << 15; wr = 1'b1; addr = 4'd4; wdata = 32'd1 << 19;
    @(negedge clk); ev = '0; wr = 1'b0;
    rd_exp(4'd8, 32'd1 << 19, "R4 set wins over clear");
    wr_reg(4'd4, 32'd1 << 19);
    rd_exp(4'd8, 32'h0, "R4 later clear");

    // per-event enable masking, channel 9 playback overflow
    wr_reg(4'd2, 32'h0);
    pulse(60'd1 << 59);
    rd_exp(4'd10, 32'd1 << 13, "R5 raw without enable");
    rd_exp(4'd14, 32'h0, "R5 masked hidden");
    repeat (2) @(negedge clk);
    check("R5 no irq when disabled", {31'd0, irq}, 32'd0);
    wr_reg(4'd2, 32'd1 << 13);
    rd_exp(4'd14, 32'd1 << 13, "R5 masked shows");
    @(negedge clk);
    check("R5 irq after enable", {31'd0, irq}, 32'd1);
    wr_reg(4'd6, 32'd1 << 13);

    // channel gate, channel 0 capture almost-empty
    wr_reg(4'd3, 32'h3FE);
    pulse(60'd1);
    repeat (3) @(negedge clk);
    check("R7 gated channel quiet", {31'd0, irq}, 32'd0);
    rd_exp(4'd12, 32'h1, "R7 masked still visible");
    wr_reg(4'd3, 32'h3FF);
    @(negedge clk);
    check("R7 irq after ungate", {31'd0, irq}, 32'd1);
    wr_reg(4'd4, 32'h1);

    // ignored writes
    wr_reg(4'd8, 32'hFFFF_FFFF);
    wr_reg(4'd13, 32'hFFFF_FFFF);
    wr_reg(4'd11, 32'hFFFF_FFFF);
    wr_reg(4'd7, 32'hFFFF_FFFF);
    rd_exp(4'd8, 32'h0, "R8 raw write ignored");
    rd_exp(4'd9, 32'h0, "R8 raw write ignored");
    rd_exp(4'd15, 32'h0, "R8 index 3 reads zero");
    rd_exp(4'd5, 32'h0, "R8 clear view reads zero");
    rd_exp(4'd0, 32'h3F3F_3F3F, "R8 enables untouched");
    rd_exp(4'd2, 32'h0000_2000, "R8 enables untouched");

    // lane mapping: channel 7 all events, channel 8 capture overflow
    pulse((60'h3F << 42) | (60'd1 << 52));
    rd_exp(4'd9, 32'h3F00_0000, "R1 channel 7 lane 3");
    rd_exp(4'd10, 32'h0000_0010, "R1 channel 8 lane 0 bit 4");
    wr_reg(4'd5, 32'hFFFF_FFFF);
    wr_reg(4'd6, 32'hFFFF_FFFF);

    // pseudo-random traffic compared with the reference every cycle
    for (int it = 0; it < 600; it++) begin
      logic [59:0] v;
      @(negedge clk);
      v = '0;
      for (int b = 0; b < 60; b++) begin
        lf = xs(lf);
        v[b] = (lf[2:0] == 3'd0);
      end
      lf = xs(lf);
      ev = v;
      wr = lf[0] & lf[1];
      addr = lf[7:4];
      wdata = xs(lf);
      #1;
      check("R8 random read", rdata, model_rd(addr));
    end
    @(negedge clk); ev = '0; wr = 1'b0;

    // reset in the middle of activity
    wr_reg(4'd3, 32'h3FF);
    wr_reg(4'd0, 32'hFFFF_FFFF);
    pulse(60'hFFF);
    @(negedge clk); #2 rst_n = 1'b0;
    @(negedge clk);
    check("R9 irq in reset", {31'd0, irq}, 32'd0);
    #2 rst_n = 1'b1;
    @(negedge clk);
    rd_exp(4'd8, 32'h0, "R9 raw cleared");
    rd_exp(4'd0, 32'h0, "R9 enables cleared");
    rd_exp(4'd3, 32'h0, "R9 channel enables cleared");

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #(8 * 200000);
    if (!done) begin
      done = 1'b1;
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual running expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule